// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is a single debug trigger that counts retired instructions and requests a breakpoint when its programmed count runs out. Software loads a 14-bit remaining count together with a set of privilege-mode enables through a control-register write port. Each instruction that retires while the hart runs in an enabled mode, with the external context check passing, takes one off the count. When a counted instruction takes the count from one to zero, the block emits a single-cycle fire pulse. The core's exception logic turns that pulse into a breakpoint exception.

A count of zero disarms the trigger. Once it has fired, the count stays at zero until software writes a new value. The full control word can be read back at any time, and the count field in it always shows the live remaining value. Fields that this trigger does not implement (action, hit, pending, debug-mode ownership) read as zero whatever was written to them. The type field always reads as the instruction-count code.

Top module: `itc_trigger`

## Requirements
- R1: After reset the count is 0, all mode enables are 0, `fire_o` is low, and `ctl_rd` reads 0x3000_0000 (type code 3 in bits 31:28, every other bit zero).
- R2: A write on `csr_wr` keeps only the count (bits 23:10) and the mode enables: U at bit 6, S at bit 7, M at bit 9, virtual-U at bit 25 and virtual-S at bit 26. Every other bit of `ctl_rd` reads zero, except bits 31:28, which always read 3.
- R3: A counted retire decrements the count by exactly one, visible in the cycle after the retire. A counted retire is `retire_i` high, the current mode enabled, `ctx_match_i` high and the count nonzero.
- R4: With `virt_i` low, the mode at `priv_i` (0 = U, 1 = S, 3 = M) counts only when its enable bit (6 + privilege) is set. Privilege code 2 never counts.
- R5: With `virt_i` high, only the virtual enables count: bit 25 for privilege 0 and bit 26 for privilege 1. The U/S/M enables are ignored, and privilege 2 or 3 never counts.
- R6: A retire in a mode that is not enabled, or with `ctx_match_i` low, leaves the count unchanged.
- R7: When the count is zero, retires neither change it nor raise `fire_o`.
- R8: `fire_o` is high for exactly one cycle: the cycle after the counted retire that takes the count from 1 to 0. It is low at all other times.
- R9: A write in the same cycle as a counted retire takes priority. The next count equals the written value, and no decrement or fire takes place in that cycle.
- R10: After firing, the count stays at zero and no further fire occurs until a new write loads a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_i | input | 1 | Hart runs in virtualized mode |
| ctx_match_i | input | 1 | Context check result for this trigger |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | XLEN | Control word write data |
| ctl_rd | output | XLEN | Control word readback with live count |
| cnt_o | output | 14 | Live remaining count |
| fire_o | output | 1 | One-cycle breakpoint request |

## Verification
If the count register went wrong, the error would show on `cnt_o` and in bits 23:10 of `ctl_rd` in the very next cycle. The bench compares both with its model after every cycle. A wrong mode decision shows up as a missing or extra decrement one cycle after the retire. A wrong zero detection shows up as a fire pulse that is missing, repeated or misplaced in the cycle after the final counted retire. A lost write priority shows up as a count one below the written value on the following cycle.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned CNT_LSB   = 10;
  localparam int unsigned BIT_U     = 6;
  localparam int unsigned BIT_S     = 7;
  localparam int unsigned BIT_M     = 9;
  localparam int unsigned BIT_VU    = 25;
  localparam int unsigned BIT_VS    = 26;
  localparam int unsigned TYPE_W    = 4;
  localparam logic [3:0]  TYPE_ICNT = 4'd3;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPV  = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } prv_e;

  typedef struct packed {
    logic vs;
    logic vu;
    logic m;
    logic s;
    logic u;
  } mode_en_t;

  function automatic mode_en_t pick_enables(input logic [31:0] w);
    mode_en_t e;
    e.u  = w[BIT_U];
    e.s  = w[BIT_S];
    e.m  = w[BIT_M];
    e.vu = w[BIT_VU];
    e.vs = w[BIT_VS];
    return e;
  endfunction

  function automatic logic mode_allowed(input mode_en_t e, input logic [1:0] p,
                                        input logic v);
    logic ok;
    ok = 1'b0;
    if (v) begin
      case (p)
        PRV_USER: ok = e.vu;
        PRV_SUPV: ok = e.vs;
        default:  ok = 1'b0;
      endcase
    end else begin
      case (p)
        PRV_USER: ok = e.u;
        PRV_SUPV: ok = e.s;
        PRV_MACH: ok = e.m;
        default:  ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic logic [CNT_W-1:0] count_less_one(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction
endpackage

// File: rtl/itc_mode_gate.sv
module itc_mode_gate
  import itc_pkg::*;
(
  input  mode_en_t   en,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       retire,
  input  logic       ctx_match,
  input  logic       armed,
  output logic       mode_ok,
  output logic       step
);
  always_comb begin
    mode_ok = mode_allowed(en, priv, virt);
    step    = retire && ctx_match && armed && mode_ok;
  end
endmodule

// File: rtl/itc_counter.sv
module itc_counter
  import itc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             last_step,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  always_comb begin
    armed     = (cnt_q != '0);
    last_step = step && !load && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      if (load) begin
        cnt_q <= load_val;
      end else if (step) begin
        cnt_q <= count_less_one(cnt_q);
      end
      fire_q <= last_step;
    end
  end

  assign cnt  = cnt_q;
  assign fire = fire_q;
endmodule

// File: rtl/itc_field_codec.sv
module itc_field_codec
  import itc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  wdata,
  input  mode_en_t         en_q,
  input  logic [CNT_W-1:0] cnt_q,
  output mode_en_t         wr_en,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [XLEN-1:0]  rd_word
);
  localparam int unsigned TYPE_LSB = XLEN - TYPE_W;

  always_comb begin
    wr_en  = pick_enables(wdata[31:0]);
    wr_cnt = wdata[CNT_LSB +: CNT_W];
  end

  always_comb begin
    rd_word                     = '0;
    rd_word[TYPE_LSB +: TYPE_W] = TYPE_ICNT;
    rd_word[CNT_LSB +: CNT_W]   = cnt_q;
    rd_word[BIT_U]              = en_q.u;
    rd_word[BIT_S]              = en_q.s;
    rd_word[BIT_M]              = en_q.m;
    rd_word[BIT_VU]             = en_q.vu;
    rd_word[BIT_VS]             = en_q.vs;
  end
endmodule

// File: rtl/itc_trigger.sv
module itc_trigger
  import itc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             ctx_match_i,
  input  logic             csr_wr,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  ctl_rd,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  mode_en_t         en_q;
  mode_en_t         wr_en;
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_armed;
  logic             cnt_step;
  logic             mode_ok;
  logic             last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (csr_wr) begin
      en_q <= wr_en;
    end
  end

  itc_field_codec #(.XLEN(XLEN)) u_codec (
    .wdata   (csr_wdata),
    .en_q    (en_q),
    .cnt_q   (cnt_q),
    .wr_en   (wr_en),
    .wr_cnt  (wr_cnt),
    .rd_word (ctl_rd)
  );

  itc_mode_gate u_gate (
    .en        (en_q),
    .priv      (priv_i),
    .virt      (virt_i),
    .retire    (retire_i),
    .ctx_match (ctx_match_i),
    .armed     (cnt_armed),
    .mode_ok   (mode_ok),
    .step      (cnt_step)
  );

  itc_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (csr_wr),
    .load_val  (wr_cnt),
    .step      (cnt_step),
    .cnt       (cnt_q),
    .armed     (cnt_armed),
    .last_step (last_step),
    .fire      (fire_o)
  );

  assign cnt_o = cnt_q;
endmodule

// File: rtl/itc_trigger_chk.sv
module itc_trigger_chk
  import itc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [1:0]       priv_i,
  input logic             virt_i,
  input logic             retire_i,
  input logic             ctx_match_i,
  input logic [CNT_W-1:0] cnt,
  input logic             step,
  input logic             fire
);
  // R3: a counted step without a write lowers the count by one
  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !csr_wr |=> cnt == $past(cnt) - CNT_W'(1));
  // R5: virtualized machine or reserved privilege never counts
  p_virt_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    virt_i && priv_i[1] |-> !step);
  // R4: reserved privilege never counts outside virtualization
  p_rsvd_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_i && priv_i == 2'd2 |-> !step);
  // R6: no step, no write, count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !csr_wr |=> $stable(cnt));
  // R6: missing context match or retire blocks the step
  p_ctx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_i && ctx_match_i) |-> !step);
  // R7: zero count stays zero without a write
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && !csr_wr |=> cnt == '0 && !fire);
  // R8: fire follows a one-to-zero transition and lasts one cycle
  p_fire_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cnt == '0 && $past(cnt) == CNT_W'(1));
  p_fire_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R9: write wins over a decrement
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> cnt == $past(csr_wdata[CNT_LSB +: CNT_W]) && !fire);
endmodule

bind itc_trigger itc_trigger_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_wr      (csr_wr),
  .csr_wdata   (csr_wdata),
  .priv_i      (priv_i),
  .virt_i      (virt_i),
  .retire_i    (retire_i),
  .ctx_match_i (ctx_match_i),
  .cnt         (cnt_o),
  .step        (cnt_step),
  .fire        (fire_o)
);

// File: tb/test_itc_trigger.sv
`timescale 1ns/1ps
module test_itc_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic [1:0]  priv_i = 2'd3;
  logic        virt_i = 1'b0;
  logic        ctx_match_i = 1'b1;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] ctl_rd;
  logic [13:0] cnt_o;
  logic        fire_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [13:0] m_cnt = '0;
  logic [4:0]  m_en = '0;   // {vs, vu, m, s, u}
  logic        m_fire = 1'b0;

  always #4 clk = ~clk;

  itc_trigger i_itc_trigger (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i),
    .virt_i(virt_i), .ctx_match_i(ctx_match_i), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .ctl_rd(ctl_rd), .cnt_o(cnt_o), .fire_o(fire_o)
  );

  function automatic bit counts_here(input logic [4:0] en, input logic [1:0] p,
                                     input logic v);
    if (v) return (p == 2'd0) ? en[3] : (p == 2'd1) ? en[4] : 1'b0;
    if (p == 2'd0) return en[0];
    if (p == 2'd1) return en[1];
    if (p == 2'd3) return en[2];
    return 1'b0;
  endfunction

  function automatic logic [31:0] word_of(input logic [13:0] c, input logic [4:0] en);
    logic [31:0] w;
    w = 32'h3000_0000;
    w = w | (32'(c) << 10);
    w[6] = en[0]; w[7] = en[1]; w[9] = en[2]; w[25] = en[3]; w[26] = en[4];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input bit ret,
                      input logic [1:0] p, input bit v, input bit ctx);
    @(negedge clk);
    csr_wr = wr; csr_wdata = wd; retire_i = ret; priv_i = p; virt_i = v; ctx_match_i = ctx;
    m_fire = 1'b0;
    if (wr) begin
      m_cnt = wd[23:10];
      m_en  = {wd[26], wd[25], wd[9], wd[7], wd[6]};
    end else if (ret && ctx && m_cnt != 0 && counts_here(m_en, p, v)) begin
      m_cnt  = m_cnt - 14'd1;
      m_fire = (m_cnt == 0);
    end
    @(posedge clk);
    #1;
    csr_wr = 1'b0; retire_i = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [13:0] c, input logic [4:0] en,
                                     input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[23:10] = c;
    w[6] = en[0]; w[7] = en[1]; w[9] = en[2]; w[25] = en[3]; w[26] = en[4];
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 ctl_rd", ctl_rd, 32'h3000_0000);
    check("R1 cnt", 32'(cnt_o), 32'd0);
    check("R1 fire", 32'(fire_o), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 write with junk in unimplemented fields
    step(1, mk(14'd5, 5'b00100, 32'hFFFF_FFFF), 0, 2'd3, 0, 1);
    check("R2 readback", ctl_rd, word_of(14'd5, 5'b00100));
    check("R2 cnt", 32'(cnt_o), 32'd5);

    // R3 decrement in M
    step(0, '0, 1, 2'd3, 0, 1);
    check("R3 dec", 32'(cnt_o), 32'd4);
    // R6 disabled mode / no ctx
    step(0, '0, 1, 2'd0, 0, 1);
    check("R6 off mode", 32'(cnt_o), 32'd4);
    step(0, '0, 1, 2'd3, 0, 0);
    check("R6 no ctx", 32'(cnt_o), 32'd4);
    // R4 reserved privilege, R5 virt ignores M enable
    step(0, '0, 1, 2'd2, 0, 1);
    check("R4 priv2", 32'(cnt_o), 32'd4);
    step(0, '0, 1, 2'd3, 1, 1);
    check("R5 virt M", 32'(cnt_o), 32'd4);

    // R5 virtual enables
    step(1, mk(14'd3, 5'b11000, 32'h0), 0, 2'd0, 1, 1);
    step(0, '0, 1, 2'd0, 1, 1);
    check("R5 vu", 32'(cnt_o), 32'd2);
    step(0, '0, 1, 2'd1, 1, 1);
    check("R5 vs", 32'(cnt_o), 32'd1);
    step(0, '0, 1, 2'd0, 0, 1);
    check("R5 plain U blocked", 32'(cnt_o), 32'd1);

    // R8 fire on 1 -> 0
    step(0, '0, 1, 2'd1, 1, 1);
    check("R8 fire", 32'(fire_o), 32'd1);
    check("R8 cnt zero", 32'(cnt_o), 32'd0);
    step(0, '0, 1, 2'd1, 1, 1);
    check("R8 one cycle", 32'(fire_o), 32'd0);
    // R7 / R10 stays zero
    step(0, '0, 1, 2'd0, 1, 1);
    check("R10 stays zero", 32'(cnt_o), 32'd0);
    check("R7 no fire", 32'(fire_o), 32'd0);

    // R9 write priority with counted retire
    step(1, mk(14'd1, 5'b00001, 32'h0), 0, 2'd0, 0, 1);
    step(1, mk(14'd9, 5'b00001, 32'h0), 1, 2'd0, 0, 1);
    check("R9 write wins", 32'(cnt_o), 32'd9);
    check("R9 no fire", 32'(fire_o), 32'd0);
    // R4 U and S bits
    step(1, mk(14'd8, 5'b00010, 32'h0), 0, 2'd0, 0, 1);
    step(0, '0, 1, 2'd1, 0, 1);
    check("R4 S", 32'(cnt_o), 32'd7);
    step(0, '0, 1, 2'd0, 0, 1);
    check("R4 U off", 32'(cnt_o), 32'd7);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit wr;
      logic [31:0] wd;
      wr = ($urandom % 20) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[23:10] = 14'($urandom % 7);
      step(wr, wd, ($urandom % 4) != 0, 2'($urandom), ($urandom % 4) == 0,
           ($urandom % 8) != 0);
      check("R3 random cnt", 32'(cnt_o), 32'(m_cnt));
      check("R8 random fire", 32'(fire_o), 32'(m_fire));
      check("R2 random readback", ctl_rd, word_of(m_cnt, m_en));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule